// File: doc/BRIEF.md
# I2C Register Write Slave

This block is the receive side of a two-wire serial control port. It watches the clock and data lines through synchronizers running on a faster system clock. It finds start and stop conditions and checks the first byte against its own seven-bit device address. When the address matches and the transfer is a write, the block acknowledges. It then takes a register index byte, followed by any number of data bytes, and stores them in a bank of 32 eight-bit registers.

The address is a fixed six-bit prefix `001001` plus one low bit taken from a strap input. After every stored byte, the register index steps forward by one. It wraps from the last register back to the first, so a burst can fill the whole bank. Acknowledge is driven as an open-drain enable: when the enable is high, the pad pulls the data line low. All register contents are presented at once on a flat parallel output for the surrounding logic.

Top module: `i2c_regwrite_slave`

## Requirements
- R1: After reset every register reads 0 and `sda_oe` is low.
- R2: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. No byte is accepted before a START.
- R3: The first byte is seven address bits, MSB first, then a direction bit. When the address equals `001001` followed by `addr_sel` and the direction bit is 0, `sda_oe` is high while the ninth clock is high.
- R4: When the address differs or the direction bit is 1, `sda_oe` stays low and no register changes until the next START.
- R5: The second byte is acknowledged. Its five low bits select the starting register, and its three high bits are ignored.
- R6: Each later byte, MSB first, is acknowledged and stored in the selected register. Register i appears on `regs_out[8*i+7:8*i]`.
- R7: After each stored byte the register index increments by one, and it wraps from 31 to 0.
- R8: A STOP in the middle of a data byte returns the block to idle without storing the partial byte.
- R9: A START in the middle of a transfer drops the current byte and restarts address matching.
- R10: At most one register changes in any system-clock cycle, and a change happens only while `sda_oe` is high.
- R11: `sda_oe` rises and falls only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap giving the low device-address bit |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| regs_out | output | 256 | All 32 registers, register i in bits 8*i+7 down to 8*i |

## Verification
The timing checks on the acknowledge enable assume that each level of the bus clock is held for longer than the synchronizer and edge-detect delay, which is about four system clocks. They also assume that the data line changes only while the bus clock is low, except at START and STOP. The stimulus holds every bus phase for five system clocks, giving a bus period of twenty system clocks. It changes the data line only in the low phase or inside the start and stop patterns. The bus data seen by the block is modelled as a wired-AND of the master's drive and the block's pull-down, so an acknowledge appears on the line the block samples.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_SUB,
        PH_SUB_ACK,
        PH_DATA,
        PH_DATA_ACK,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [6:0] got,
                                     input logic [5:0] prefix,
                                     input logic       strap);
        return got == {prefix, strap};
    endfunction

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync
    import i2cw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now;
    logic [LINES-1:0] prev;

    assign raw = {scl_raw, sda_raw};

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh      <= '1;
                prev[l] <= 1'b1;
            end else begin
                sh      <= {sh[STAGES-2:0], raw[l]};
                prev[l] <= sh[STAGES-1];
            end
        end
        assign now[l] = sh[STAGES-1];
    end

    always_comb begin
        ev.start    = now[1] & prev[1] & prev[0] & ~now[0];
        ev.stop     = now[1] & prev[1] & ~prev[0] & now[0];
        ev.scl_rise = now[1] & ~prev[1];
        ev.scl_fall = ~now[1] & prev[1];
        ev.sda      = now[0];
    end

endmodule

// File: rtl/i2cw_proto.sv
module i2cw_proto
    import i2cw_pkg::*;
#(
    parameter logic [5:0] DEV_PREFIX = 6'b001001,
    parameter int          IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [IDX_W-1:0]  ptr_val,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [3:0] FULL = 4'(BYTE_W);

    phase_e            phase;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;

    assign ptr_val = shreg[IDX_W-1:0];
    assign wr_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            ptr_load <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            ptr_load <= 1'b0;
            wr_en    <= 1'b0;
            if (ev.start) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_SUB, PH_DATA: begin
                        if (ev.scl_rise && bit_cnt < FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            if (phase == PH_ADDR) begin
                                if (dev_hit(shreg[7:1], DEV_PREFIX, addr_sel)
                                    && !shreg[0]) begin
                                    phase  <= PH_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    phase <= PH_SKIP;
                                end
                            end else if (phase == PH_SUB) begin
                                ptr_load <= 1'b1;
                                phase    <= PH_SUB_ACK;
                                sda_oe   <= 1'b1;
                            end else begin
                                wr_en  <= 1'b1;
                                phase  <= PH_DATA_ACK;
                                sda_oe <= 1'b1;
                            end
                        end
                    end
                    PH_ADDR_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_SUB;
                    end
                    PH_SUB_ACK, PH_DATA_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_DATA;
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ptr_load,
    input  logic [IDX_W-1:0]           ptr_val,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= (ptr_val <= LAST) ? ptr_val : '0;
        end else if (wr_en) begin
            ptr <= (ptr == LAST) ? '0 : ptr + IDX_W'(1);
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && ptr == IDX_W'(i)) begin
                q <= wr_data;
            end
        end
        assign regs_flat[i*BYTE_W +: BYTE_W] = q;
    end

endmodule

// File: rtl/i2c_regwrite_slave.sv
module i2c_regwrite_slave
    import i2cw_pkg::*;
#(
    parameter int          NUM_REGS    = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [5:0]  DEV_PREFIX  = 6'b001001
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           scl_in,
    input  logic                           sda_in,
    input  logic                           addr_sel,
    output logic                           sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0]     regs_out
);

    localparam int IDX_W = $clog2(NUM_REGS);

    bus_ev_t           ev;
    logic              ptr_load;
    logic [IDX_W-1:0]  ptr_val;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;

    i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .ev      (ev)
    );

    i2cw_proto #(.DEV_PREFIX(DEV_PREFIX), .IDX_W(IDX_W)) u_proto (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    i2cw_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ptr_load  (ptr_load),
        .ptr_val   (ptr_val),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .regs_flat (regs_out)
    );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
    parameter int NUM_REGS = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_in,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs_out
);

    logic [NUM_REGS*8-1:0] prev_regs;
    logic [NUM_REGS-1:0]   changed;
    logic                  rst_q = 1'b0;

    always_ff @(posedge clk) begin
        prev_regs <= regs_out;
        rst_q     <= rst;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chg
        assign changed[i] = regs_out[i*8 +: 8] != prev_regs[i*8 +: 8];
    end

    // R1
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            reset_clear_chk: assert (sda_oe == 1'b0 && regs_out == '0)
                else $error("reset state not clear");
        end
    end

    // R10
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(changed));

    // R10
    write_under_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (changed != '0) |-> sda_oe);

    // R11
    ack_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in);

    // R11
    ack_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_in);

endmodule

bind i2c_regwrite_slave i2cw_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .regs_out (regs_out)
);

// File: tb/i2c_regwrite_slave_bench.sv
module i2c_regwrite_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int NREG       = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] regs_out;

    logic [7:0] exp_regs [NREG];
    int checks = 0;
    int failures = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regwrite_slave u_i2c_regwrite_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .regs_out (regs_out)
    );

    task automatic chk(input bit ok, input string tag,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_clk(Q);
        // R11: enable never held into a data bit
        chk(sda_oe == 1'b0, "R11 enable low before data bit", sda_oe, 0);
        scl_m = 1'b1; wait_clk(2*Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic ack_slot(output logic acked);
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        acked = !sda_line;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        ack_slot(acked);
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(regs_out[i*8 +: 8] == exp_regs[i], tag,
                regs_out[i*8 +: 8], exp_regs[i]);
    endtask

    task automatic burst(input logic [7:0] sub, input int n,
                         input int base, input int step, input string tag);
        logic a;
        int idx;
        bus_start();
        send_byte({6'b001001, addr_sel, 1'b0}, a);
        chk(a == 1'b1, {tag, " address ack (R3)"}, a, 1);
        send_byte(sub, a);
        chk(a == 1'b1, {tag, " sub-address ack (R5)"}, a, 1);
        idx = int'(sub[4:0]);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'(base + k*step);
            send_byte(d, a);
            chk(a == 1'b1, {tag, " data ack (R6)"}, a, 1);
            exp_regs[idx] = d;
            idx = (idx + 1) % NREG;
        end
        bus_stop();
        wait_clk(4);
        check_regs(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1
        chk(sda_oe == 1'b0, "R1 enable after reset", sda_oe, 0);
        check_regs("R1 registers after reset");

        // R2: bytes with no START are ignored
        for (int i = 7; i >= 0; i--) send_bit(logic'(8'h24 >> i));
        ack_slot(a);
        chk(a == 1'b0, "R2 no ack without START", a, 1'b0);

        // R3 / R4: sweep all device addresses for both strap levels
        for (int s = 0; s < 2; s++) begin
            addr_sel = logic'(s);
            for (int ad = 0; ad < 128; ad++) begin
                bit exp_ack;
                exp_ack = (ad == (8'h12 | s));
                bus_start();
                send_byte({7'(ad), 1'b0}, a);
                chk(a == exp_ack, "R3/R4 address sweep ack", a, exp_ack);
                bus_stop();
            end
        end

        addr_sel = 1'b1;
        // R4: read direction is not acknowledged and data is not stored
        bus_start();
        send_byte({7'h13, 1'b1}, a);
        chk(a == 1'b0, "R4 read direction nack", a, 0);
        send_byte(8'h02, a);
        chk(a == 1'b0, "R4 ignored byte nack", a, 0);
        send_byte(8'hAA, a);
        chk(a == 1'b0, "R4 ignored byte nack", a, 0);
        bus_stop();
        wait_clk(4);
        check_regs("R4 no change after read direction");

        // R4: wrong address followed by bytes
        bus_start();
        send_byte({7'h12, 1'b0}, a);
        chk(a == 1'b0, "R4 mismatch nack", a, 0);
        send_byte(8'h00, a);
        send_byte(8'h77, a);
        chk(a == 1'b0, "R4 mismatch data nack", a, 0);
        bus_stop();
        wait_clk(4);
        check_regs("R4 no change after mismatch");

        // R6 / R7: fill the whole bank in one burst
        burst(8'h00, NREG, 5, 37, "R6 full burst");
        // R7: wrap from 31 to 0
        burst(8'h1E, 4, 8'hA0, 1, "R7 wrap burst");
        // R5: high sub-address bits ignored
        burst(8'hE3, 1, 8'h5C, 0, "R5 high bits ignored");

        // R8: STOP mid-byte drops the partial byte
        bus_start();
        send_byte({7'h13, 1'b0}, a);
        send_byte(8'h07, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        wait_clk(4);
        check_regs("R8 partial byte dropped");

        // R9: repeated START mid-byte restarts matching
        bus_start();
        send_byte({7'h13, 1'b0}, a);
        send_byte(8'h09, a);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        send_byte({7'h13, 1'b0}, a);
        chk(a == 1'b1, "R9 ack after repeated START", a, 1);
        send_byte(8'h0A, a);
        send_byte(8'h3C, a);
        chk(a == 1'b1, "R9 data ack after repeated START", a, 1);
        exp_regs[10] = 8'h3C;
        bus_stop();
        wait_clk(4);
        check_regs("R9 repeated START write");

        // R9 / R4: skipped transfer recovers at the next START
        bus_start();
        send_byte({7'h20, 1'b0}, a);
        chk(a == 1'b0, "R4 mismatch before repeated START", a, 0);
        bus_start();
        send_byte({7'h13, 1'b0}, a);
        chk(a == 1'b1, "R9 ack after skip", a, 1);
        send_byte(8'h1F, a);
        send_byte(8'hC3, a);
        send_byte(8'h81, a);
        exp_regs[31] = 8'hC3;
        exp_regs[0]  = 8'h81;
        bus_stop();
        wait_clk(4);
        // R10: only the addressed registers changed
        check_regs("R10 R7 writes after skip");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule